// File: doc/BRIEF.md
# Instruction Stream Signature Checker

This block checks that a processor both fetched and sequenced its instructions correctly. Each time an instruction retires, the block folds the instruction word into a signature register that is exactly one word wide. Before each fold, the register takes one step of a maximal-length linear-feedback shift. The code is laid out in straight-line chunks. Each chunk starts with a free "dummy" word and ends with its only jump. The dummy is chosen so that the signature returns to zero once the closing jump has been folded in. A nonzero signature at that point means a wrong word was fetched, a word was corrupted, or control went somewhere it should not have. The block then raises a sticky fault and, in the same cycle, a halt request.

The word retired right after any jump is the next chunk's dummy. The block tells the decoder to execute that word as a skip, whatever its bits are, but the word is still folded into the signature. A failed check does not clear the signature. The residue keeps being stepped, so later chunk-end checks get another chance to see it.

Top module: `fetch_sig_guard`

## Requirements
- R1: After reset the signature is zero, and `fault_o`, `halt_req_o` and `dummy_next_o` are all low.
- R2: On a retire strobe the signature becomes step(S) XOR word. Step shifts S left by one and, if the bit shifted out was 1, XORs the tap mask into the result. The default mask is 0x53 (bits 0, 1, 4, 6, for x^30+x^6+x^4+x+1). Bitwise XOR means no carries are involved.
- R3: In a cycle with no retire strobe and no clear, the signature does not change.
- R4: A retiring jump whose folded value is nonzero raises `halt_req_o` in that same cycle and sets `fault_o` from the next cycle on.
- R5: A retiring jump whose folded value is zero leaves `fault_o` unchanged. This applies to taken and untaken jumps alike.
- R6: `fault_o` stays high until a clear. A failed check leaves the folded value in the signature, and that value keeps being stepped.
- R7: A retired jump sets `dummy_next_o`, and the next retired non-jump clears it. A jump that is itself the dummy word is still checked and keeps the flag set.
- R8: A synchronous clear zeroes the signature, `fault_o` and `dummy_next_o`, and it takes priority over a retire in the same cycle.
- R9: With a zero signature, retiring a zero word keeps the signature zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of signature, fault and dummy flag |
| retire_i | input | 1 | An instruction finished executing this cycle |
| word_i | input | WIDTH | Word of the retiring instruction |
| jump_i | input | 1 | Retiring instruction is a jump (taken or not) |
| sig_o | output | WIDTH | Current signature |
| fault_o | output | 1 | Sticky chunk-check failure |
| halt_req_o | output | 1 | Fault detected this cycle |
| dummy_next_o | output | 1 | Next retired word is to be executed as a skip |

## Verification
The bench closes chunks with a computed cancelling word. It does this both on signatures whose top bit is set and on signatures whose top bit is clear. A tap placed in the wrong position, or a step that ignores the shifted-out bit, would then leave a nonzero residue and raise false faults. Other chunks are deliberately closed wrong. A design that checked before folding, or that cleared the residue on failure, would then miss the fault or lose the later second chance. Back-to-back jumps and a clear arriving together with a retire are also driven. These expose a dummy flag that suppresses the check, or a clear that loses to the fold.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int DEF_WIDTH = 30;
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 30'h0000_0053;

    typedef enum logic [1:0] {
        CHK_NONE = 2'd0,
        CHK_PASS = 2'd1,
        CHK_FAIL = 2'd2
    } chk_e;

    typedef struct packed {
        logic retire;
        logic jump;
        logic clear;
    } evt_t;
endpackage

// File: rtl/fsg_fold.sv
module fsg_fold #(
    parameter int WIDTH = fsg_pkg::DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS = fsg_pkg::DEF_TAPS
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] folded_o
);
    logic             msb;
    logic [WIDTH-1:0] stepped;

    assign msb = cur_i[WIDTH-1];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == 0) begin : g_lsb
            assign stepped[b] = TAPS[b] & msb;
        end else begin : g_upper
            assign stepped[b] = cur_i[b-1] ^ (TAPS[b] & msb);
        end
    end

    assign folded_o = stepped ^ word_i;
endmodule

// File: rtl/fsg_sig_reg.sv
module fsg_sig_reg #(
    parameter int WIDTH = fsg_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  fsg_pkg::evt_t    evt_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst || evt_i.clear) begin
            q_o <= '0;
        end else if (evt_i.retire) begin
            q_o <= d_i;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!evt_i.retire && !evt_i.clear) |=> $stable(q_o));

    p_clear_sig_r8: assert property (@(posedge clk) disable iff (rst)
        evt_i.clear |=> (q_o == '0));
endmodule

// File: rtl/fsg_chunk_mon.sv
module fsg_chunk_mon #(
    parameter bit HALT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  fsg_pkg::evt_t evt_i,
    input  logic          folded_zero_i,
    output logic          fault_o,
    output logic          halt_req_o,
    output logic          dummy_next_o
);
    import fsg_pkg::*;

    chk_e chk;

    always_comb begin
        chk = CHK_NONE;
        if (evt_i.retire && evt_i.jump && !evt_i.clear) begin
            chk = folded_zero_i ? CHK_PASS : CHK_FAIL;
        end
    end

    assign halt_req_o = HALT_EN && (chk == CHK_FAIL);

    always_ff @(posedge clk) begin
        if (rst || evt_i.clear) begin
            fault_o      <= 1'b0;
            dummy_next_o <= 1'b0;
        end else begin
            if (chk == CHK_FAIL) begin
                fault_o <= 1'b1;
            end
            if (evt_i.retire) begin
                dummy_next_o <= evt_i.jump;
            end
        end
    end

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !evt_i.clear) |=> fault_o);

    p_halt_sets_fault_r4: assert property (@(posedge clk) disable iff (rst)
        halt_req_o |=> fault_o);

    p_dummy_after_jump_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.retire && evt_i.jump && !evt_i.clear) |=> dummy_next_o);

    p_dummy_drops_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.retire && !evt_i.jump) |=> !dummy_next_o);

    p_clear_flags_r8: assert property (@(posedge clk) disable iff (rst)
        evt_i.clear |=> (!fault_o && !dummy_next_o));
endmodule

// File: rtl/fetch_sig_guard.sv
module fetch_sig_guard #(
    parameter int WIDTH = fsg_pkg::DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS = fsg_pkg::DEF_TAPS,
    parameter bit HALT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             retire_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             jump_i,
    output logic [WIDTH-1:0] sig_o,
    output logic             fault_o,
    output logic             halt_req_o,
    output logic             dummy_next_o
);
    import fsg_pkg::*;

    evt_t             evt;
    logic [WIDTH-1:0] folded;
    logic             folded_zero;

    assign evt.retire  = retire_i;
    assign evt.jump    = jump_i;
    assign evt.clear   = clr_i;
    assign folded_zero = (folded == '0);

    fsg_fold #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fold (
        .cur_i    (sig_o),
        .word_i   (word_i),
        .folded_o (folded)
    );

    fsg_sig_reg #(.WIDTH(WIDTH)) u_sig (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .d_i   (folded),
        .q_o   (sig_o)
    );

    fsg_chunk_mon #(.HALT_EN(HALT_EN)) u_mon (
        .clk           (clk),
        .rst           (rst),
        .evt_i         (evt),
        .folded_zero_i (folded_zero),
        .fault_o       (fault_o),
        .halt_req_o    (halt_req_o),
        .dummy_next_o  (dummy_next_o)
    );

    p_zero_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !clr_i && sig_o == '0 && word_i == '0) |=> (sig_o == '0));

    p_pass_keeps_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (retire_i && jump_i && !clr_i && !fault_o && folded_zero) |=> !fault_o);
endmodule

// File: tb/fetch_sig_guard_bench.sv
module fetch_sig_guard_bench;
    localparam int W = 30;
    localparam logic [W-1:0] POLY_LOW = 30'h53;

    logic         clk = 1'b0;
    logic         rst;
    logic         clr_i;
    logic         retire_i;
    logic [W-1:0] word_i;
    logic         jump_i;
    logic [W-1:0] sig_o;
    logic         fault_o;
    logic         halt_req_o;
    logic         dummy_next_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    logic [W-1:0] m_sig;
    logic         m_fault;
    logic         m_dummy;

    always #2 clk = ~clk;

    fetch_sig_guard u_fetch_sig_guard (
        .clk(clk), .rst(rst), .clr_i(clr_i), .retire_i(retire_i),
        .word_i(word_i), .jump_i(jump_i), .sig_o(sig_o), .fault_o(fault_o),
        .halt_req_o(halt_req_o), .dummy_next_o(dummy_next_o)
    );

    // multiply by x modulo the feedback polynomial
    function automatic logic [W-1:0] times_x(input logic [W-1:0] v);
        logic [W:0] wide;
        wide = {v, 1'b0};
        if (wide[W]) wide[W-1:0] = wide[W-1:0] ^ POLY_LOW;
        return wide[W-1:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk({req, " sig"},   64'(sig_o),        64'(m_sig));
        chk({req, " fault"}, 64'(fault_o),      64'(m_fault));
        chk({req, " dummy"}, 64'(dummy_next_o), 64'(m_dummy));
    endtask

    // drive one cycle at negedge, check halt, then model the edge
    task automatic cyc(input string req, input logic r, input logic [W-1:0] w,
                       input logic j, input logic c);
        logic [W-1:0] f;
        logic         exp_halt;
        retire_i = r; word_i = w; jump_i = j; clr_i = c;
        f = times_x(m_sig) ^ w;
        exp_halt = r && j && !c && (f != '0);
        #1;
        chk({req, " halt"}, 64'(halt_req_o), 64'(exp_halt));
        @(posedge clk);
        if (c) begin
            m_sig = '0; m_fault = 0; m_dummy = 0;
        end else if (r) begin
            m_sig = f;
            if (exp_halt) m_fault = 1;
            m_dummy = j;
        end
        @(negedge clk);
        compare_all(req);
        retire_i = 0; jump_i = 0; clr_i = 0;
    endtask

    function automatic logic [W-1:0] cancel_word();
        return times_x(m_sig);
    endfunction

    task automatic good_chunk(input string req, input int n);
        cyc({req, " dummy"}, 1, W'($urandom), 0, 0);
        for (int i = 0; i < n; i++) cyc({req, " body"}, 1, W'($urandom), 0, 0);
        cyc({req, " close"}, 1, cancel_word(), 1, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                done = 1;
                fails++;
                tests++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1; clr_i = 0; retire_i = 0; word_i = '0; jump_i = 0;
        m_sig = '0; m_fault = 0; m_dummy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all("R1 reset");
        chk("R1 halt", 64'(halt_req_o), 64'(0));

        // R9 zero in, zero stays
        cyc("R9 zero word", 1, '0, 0, 0);
        // R2 fold with several patterns, including MSB set
        cyc("R2 fold a", 1, 30'h2000_0001, 0, 0);
        cyc("R2 fold b", 1, 30'h3FFF_FFFF, 0, 0);
        cyc("R2 fold c", 1, 30'h1555_5555, 0, 0);
        for (int i = 0; i < 20; i++) cyc("R2 fold rand", 1, W'($urandom), 0, 0);
        // R3 idle cycles hold
        cyc("R3 idle", 0, W'($urandom), 0, 0);
        cyc("R3 idle jump pin", 0, W'($urandom), 1, 0);
        // R5 good close (MSB of sig probably mixed); R7 dummy set
        cyc("R5 close", 1, cancel_word(), 1, 0);
        // R7 dummy cleared by next non-jump
        good_chunk("R5 R7 chunk", 5);
        // force MSB set before close for tap check
        cyc("R2 msb prep", 1, 30'h2000_0000 ^ times_x(m_sig), 0, 0);
        cyc("R5 close msb", 1, cancel_word(), 1, 0);
        // R7 jump as dummy word: still checked, flag kept
        cyc("R7 jump dummy pass", 1, cancel_word(), 1, 0);
        cyc("R7 jump dummy fail", 1, 30'h0000_0123 ^ cancel_word(), 1, 0);
        // R4/R6 residue kept, fault sticky
        cyc("R6 residue step", 1, W'($urandom), 0, 0);
        good_chunk("R6 sticky", 3);
        cyc("R6 idle", 0, '0, 0, 0);
        // R8 clear with retire same cycle
        cyc("R8 clear", 1, W'($urandom), 1, 1);
        // R4 fresh failure after clear
        cyc("R4 body", 1, 30'h0ABC_DEF0, 0, 0);
        cyc("R4 bad close", 1, 30'h0000_0001, 1, 0);
        cyc("R8 clear idle", 0, '0, 0, 1);
        good_chunk("R5 after clear", 8);
        for (int i = 0; i < 30; i++) good_chunk("R2 R5 stress", i % 7);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule